// File: doc/BRIEF.md
# Thread-Partitioned Banked Register File

This block is the general-purpose register storage of a multithreaded processing engine. It has two banks, A and B, of 128 words of 32 bits each, 256 words in all. It has one write port that can reach either bank and one read port for each bank. Every access carries a thread number, a register number and a mode bit. In absolute mode the register number is the physical word in the bank, so any thread can reach any word and threads can pass data to each other. In thread-local mode the register number counts from the start of the calling thread's private slice.

The engine runs either eight or four threads. With eight threads each thread owns 16 words per bank (32 in all). With four threads each owns 32 words per bank (64 in all). A local access that falls outside the caller's slice is refused. A refused write stores nothing and raises an error pulse. A refused read returns a flagged response with zero data.

Request ports use valid/ready. The ready outputs are always high, because the file takes one request per port in every cycle and never applies back-pressure. A read answers exactly one cycle after it is accepted, through a response valid that has no ready, so the consumer must take the response in that cycle. The thread-count selection is a plain control pin.

Top module: `gpr_banked_file`

## Requirements
- R1: After reset every word of both banks reads as zero, the response valids and both error outputs are low, and the active configuration is eight threads.
- R2: In absolute mode (abs bit = 1) the register number 0..127 is the physical word, whatever the thread. Such an access is never refused, so a word written by one thread can be read by another.
- R3: In eight-thread mode (cfg pin = 0, with the pin sampled as in R6) a local access is legal only for register numbers 0..15, and it reaches word thread*16 + register. All thread numbers 0..7 are valid.
- R4: In four-thread mode (cfg pin = 1, with the pin sampled as in R6) a local access is legal only for threads 0..3 and register numbers 0..31, and it reaches word thread*32 + register.
- R5: A refused local write leaves every word unchanged and raises wr_err for one cycle, in the cycle after the request. A refused local read gives rvalid = 1, err = 1 and data = 0.
- R6: The cfg pin is taken into the active configuration only at the end of a cycle in which no port has valid high. While any request is present the active configuration holds. Changing it clears no word.
- R7: A read and a write of the same word in the same cycle return the old value. The new value is returned from the next cycle on.
- R8: A read accepted in a cycle gives rvalid = 1 with its data in the next cycle. A cycle with no read accepted gives rvalid = 0 in the next cycle. All ready outputs stay high.
- R9: The two banks are separate. A write selects bank B when wr_bank = 1 and bank A when it is 0, and it changes no word of the other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_four_thr | input | 1 | Thread-count selection: 1 for four threads, 0 for eight threads (sampled in idle cycles only) |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request ready (always high) |
| wr_thread | input | 3 | Thread number of the writer |
| wr_bank | input | 1 | Target bank: 0 for A, 1 for B |
| wr_abs | input | 1 | 1 for absolute mode, 0 for thread-local mode |
| wr_reg | input | 7 | Register number |
| wr_data | input | 32 | Write data |
| wr_err | output | 1 | Pulse: the previous cycle's write was refused |
| ra_valid | input | 1 | Bank A read request valid |
| ra_ready | output | 1 | Bank A read request ready (always high) |
| ra_thread | input | 3 | Thread number of the bank A reader |
| ra_abs | input | 1 | Bank A read mode: 1 for absolute, 0 for local |
| ra_reg | input | 7 | Bank A register number |
| ra_rvalid | output | 1 | Bank A response valid |
| ra_err | output | 1 | Bank A response was refused |
| ra_data | output | 32 | Bank A response data |
| rb_valid | input | 1 | Bank B read request valid |
| rb_ready | output | 1 | Bank B read request ready (always high) |
| rb_thread | input | 3 | Thread number of the bank B reader |
| rb_abs | input | 1 | Bank B read mode: 1 for absolute, 0 for local |
| rb_reg | input | 7 | Bank B register number |
| rb_rvalid | output | 1 | Bank B response valid |
| rb_err | output | 1 | Bank B response was refused |
| rb_data | output | 32 | Bank B response data |

## Verification
The file is driven with directed patterns first and then with random traffic. A write in absolute mode followed by a local read from another thread tells the absolute mapping from the local mapping. Register numbers just inside and just outside a slice, in both thread counts, show where the slice limits sit and whether a refused write is really dropped. A change of the cfg pin during busy cycles and then during an idle cycle shows whether the configuration is taken at the right moment. Same-cycle write and read of one word shows read-before-write. Writes to one bank followed by reads of the other show that the banks are kept apart.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int DATA_W_DEF     = 32;
  localparam int BANK_DEPTH_DEF = 128;
  localparam int N_BANKS_DEF    = 2;
  localparam int THR_HI_DEF     = 8;
  localparam int THR_LO_DEF     = 4;

  typedef enum logic {
    MODE_HI_THREADS = 1'b0,
    MODE_LO_THREADS = 1'b1
  } thr_mode_e;
endpackage

// File: rtl/gpr_slice_map.sv
module gpr_slice_map #(
  parameter int DEPTH  = 128,
  parameter int THR_HI = 8,
  parameter int THR_LO = 4,
  parameter int THR_W  = $clog2(THR_HI),
  parameter int REG_W  = $clog2(DEPTH)
) (
  input  logic [THR_W-1:0] thread,
  input  logic             abs_mode,
  input  logic [REG_W-1:0] reg_num,
  input  gpr_pkg::thr_mode_e mode,
  output logic [REG_W-1:0] phys,
  output logic             legal
);
  localparam int PW        = REG_W + THR_W + 1;
  localparam int SLICE_HI  = DEPTH / THR_HI;
  localparam int SLICE_LO  = DEPTH / THR_LO;

  logic [PW-1:0] slice_sz;
  logic [PW-1:0] thr_lim;
  logic [PW-1:0] wide_idx;
  logic          in_slice;

  always_comb begin
    if (mode == gpr_pkg::MODE_LO_THREADS) begin
      slice_sz = PW'(SLICE_LO);
      thr_lim  = PW'(THR_LO);
    end else begin
      slice_sz = PW'(SLICE_HI);
      thr_lim  = PW'(THR_HI);
    end
    wide_idx = PW'(thread) * slice_sz + PW'(reg_num);
    in_slice = (PW'(reg_num) < slice_sz) && (PW'(thread) < thr_lim);
    legal    = abs_mode || in_slice;
    phys     = abs_mode ? reg_num : wide_idx[REG_W-1:0];
  end
endmodule

// File: rtl/gpr_mode_ctl.sv
module gpr_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_four_thr,
  input  logic busy,
  output gpr_pkg::thr_mode_e mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= gpr_pkg::MODE_HI_THREADS;
    end else if (!busy) begin
      mode_q <= cfg_four_thr ? gpr_pkg::MODE_LO_THREADS : gpr_pkg::MODE_HI_THREADS;
    end
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 32,
  parameter int REG_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [REG_W-1:0]  raddr,
  input  logic              rlegal,
  output logic              rvalid,
  output logic              rerr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (we) begin
      store[waddr] <= wdata;
    end
  end

  // The response samples the array before this edge's write lands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rerr   <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= re;
      rerr   <= re && !rlegal;
      rdata  <= (re && rlegal) ? store[raddr] : '0;
    end
  end
endmodule

// File: rtl/gpr_banked_file.sv
module gpr_banked_file #(
  parameter int DATA_W     = gpr_pkg::DATA_W_DEF,
  parameter int BANK_DEPTH = gpr_pkg::BANK_DEPTH_DEF,
  parameter int THR_HI     = gpr_pkg::THR_HI_DEF,
  parameter int THR_LO     = gpr_pkg::THR_LO_DEF,
  parameter int THR_W      = $clog2(THR_HI),
  parameter int REG_W      = $clog2(BANK_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_four_thr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [THR_W-1:0]  wr_thread,
  input  logic              wr_bank,
  input  logic              wr_abs,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_err,
  input  logic              ra_valid,
  output logic              ra_ready,
  input  logic [THR_W-1:0]  ra_thread,
  input  logic              ra_abs,
  input  logic [REG_W-1:0]  ra_reg,
  output logic              ra_rvalid,
  output logic              ra_err,
  output logic [DATA_W-1:0] ra_data,
  input  logic              rb_valid,
  output logic              rb_ready,
  input  logic [THR_W-1:0]  rb_thread,
  input  logic              rb_abs,
  input  logic [REG_W-1:0]  rb_reg,
  output logic              rb_rvalid,
  output logic              rb_err,
  output logic [DATA_W-1:0] rb_data
);
  localparam int N_BANKS = gpr_pkg::N_BANKS_DEF;

  gpr_pkg::thr_mode_e mode_q;
  logic               busy;

  logic              rd_v   [N_BANKS];
  logic [THR_W-1:0]  rd_t   [N_BANKS];
  logic              rd_a   [N_BANKS];
  logic [REG_W-1:0]  rd_r   [N_BANKS];
  logic [REG_W-1:0]  rd_p   [N_BANKS];
  logic              rd_ok  [N_BANKS];
  logic              rs_v   [N_BANKS];
  logic              rs_e   [N_BANKS];
  logic [DATA_W-1:0] rs_d   [N_BANKS];

  logic [REG_W-1:0]  w_phys;
  logic              w_legal;
  logic              wr_err_q;

  assign rd_v[0] = ra_valid;  assign rd_v[1] = rb_valid;
  assign rd_t[0] = ra_thread; assign rd_t[1] = rb_thread;
  assign rd_a[0] = ra_abs;    assign rd_a[1] = rb_abs;
  assign rd_r[0] = ra_reg;    assign rd_r[1] = rb_reg;

  assign busy     = wr_valid || ra_valid || rb_valid;
  assign wr_ready = 1'b1;
  assign ra_ready = 1'b1;
  assign rb_ready = 1'b1;

  gpr_mode_ctl u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_four_thr (cfg_four_thr),
    .busy         (busy),
    .mode_q       (mode_q)
  );

  gpr_slice_map #(
    .DEPTH (BANK_DEPTH), .THR_HI (THR_HI), .THR_LO (THR_LO),
    .THR_W (THR_W), .REG_W (REG_W)
  ) u_wmap (
    .thread   (wr_thread),
    .abs_mode (wr_abs),
    .reg_num  (wr_reg),
    .mode     (mode_q),
    .phys     (w_phys),
    .legal    (w_legal)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    gpr_slice_map #(
      .DEPTH (BANK_DEPTH), .THR_HI (THR_HI), .THR_LO (THR_LO),
      .THR_W (THR_W), .REG_W (REG_W)
    ) u_rmap (
      .thread   (rd_t[b]),
      .abs_mode (rd_a[b]),
      .reg_num  (rd_r[b]),
      .mode     (mode_q),
      .phys     (rd_p[b]),
      .legal    (rd_ok[b])
    );

    gpr_bank #(
      .DEPTH (BANK_DEPTH), .DATA_W (DATA_W), .REG_W (REG_W)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wr_valid && w_legal && (wr_bank == 1'(b))),
      .waddr  (w_phys),
      .wdata  (wr_data),
      .re     (rd_v[b]),
      .raddr  (rd_p[b]),
      .rlegal (rd_ok[b]),
      .rvalid (rs_v[b]),
      .rerr   (rs_e[b]),
      .rdata  (rs_d[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_err_q <= 1'b0;
    else        wr_err_q <= wr_valid && !w_legal;
  end

  assign wr_err    = wr_err_q;
  assign ra_rvalid = rs_v[0];
  assign ra_err    = rs_e[0];
  assign ra_data   = rs_d[0];
  assign rb_rvalid = rs_v[1];
  assign rb_err    = rs_e[1];
  assign rb_data   = rs_d[1];
endmodule

// File: rtl/gpr_checker.sv
module gpr_checker #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_abs,
  input logic [REG_W-1:0]  wr_reg,
  input logic              wr_err,
  input logic              ra_valid,
  input logic              ra_abs,
  input logic              ra_rvalid,
  input logic              ra_err,
  input logic [DATA_W-1:0] ra_data,
  input logic              rb_valid,
  input logic              rb_rvalid,
  input logic              rb_err,
  input logic [DATA_W-1:0] rb_data,
  input logic              mode_q
);
  assert_rvalid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ra_valid |=> ra_rvalid);

  assert_no_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_valid |=> !rb_rvalid);

  assert_abs_never_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_valid && ra_abs) |=> !ra_err);

  assert_refused_zero_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_rvalid && ra_err) |-> (ra_data == '0));

  assert_refused_zero_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_rvalid && rb_err) |-> (rb_data == '0));

  assert_wide_local_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_abs && (wr_reg >= REG_W'(32))) |=> wr_err);

  assert_cfg_held_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || ra_valid || rb_valid) |=> $stable(mode_q));
endmodule

bind gpr_banked_file gpr_checker #(.DATA_W(DATA_W), .REG_W(REG_W)) u_gpr_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_abs    (wr_abs),
  .wr_reg    (wr_reg),
  .wr_err    (wr_err),
  .ra_valid  (ra_valid),
  .ra_abs    (ra_abs),
  .ra_rvalid (ra_rvalid),
  .ra_err    (ra_err),
  .ra_data   (ra_data),
  .rb_valid  (rb_valid),
  .rb_rvalid (rb_rvalid),
  .rb_err    (rb_err),
  .rb_data   (rb_data),
  .mode_q    (mode_q)
);

// File: tb/test_gpr_banked_file.sv
module test_gpr_banked_file;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg;
  logic        wv, wbk, wab;
  logic [2:0]  wt;
  logic [6:0]  wr;
  logic [31:0] wd;
  logic        rv [2];
  logic [2:0]  rt [2];
  logic        rab [2];
  logic [6:0]  rr [2];
  logic        wrdy, wer;
  logic        ordy [2];
  logic        orv [2];
  logic        oer [2];
  logic [31:0] od [2];

  gpr_banked_file i_gpr_banked_file (
    .clk(clk), .rst_n(rst_n), .cfg_four_thr(cfg),
    .wr_valid(wv), .wr_ready(wrdy), .wr_thread(wt), .wr_bank(wbk),
    .wr_abs(wab), .wr_reg(wr), .wr_data(wd), .wr_err(wer),
    .ra_valid(rv[0]), .ra_ready(ordy[0]), .ra_thread(rt[0]), .ra_abs(rab[0]),
    .ra_reg(rr[0]), .ra_rvalid(orv[0]), .ra_err(oer[0]), .ra_data(od[0]),
    .rb_valid(rv[1]), .rb_ready(ordy[1]), .rb_thread(rt[1]), .rb_abs(rab[1]),
    .rb_reg(rr[1]), .rb_rvalid(orv[1]), .rb_err(oer[1]), .rb_data(od[1])
  );

  int unsigned mem [2][128];
  bit          m4;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;
  string       focus = "";

  task automatic chk(string tag, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit legal(int t, bit ab, int r, bit four);
    if (ab) return 1;
    if (four) return (t < 4) && (r < 32);
    return r < 16;
  endfunction

  function automatic int pidx(int t, bit ab, int r, bit four);
    if (ab) return r;
    return four ? t * 32 + r : t * 16 + r;
  endfunction

  function automatic string tag_of(int t, bit ab, int r, bit four);
    if (focus != "") return focus;
    if (!legal(t, ab, r, four)) return "R5";
    if (ab) return "R2";
    return four ? "R4" : "R3";
  endfunction

  // Apply the inputs already set, advance one clock, compare at the next negedge.
  task automatic tick();
    bit          e_rv [2];
    bit          e_er [2];
    int unsigned e_d  [2];
    string       tg   [2];
    bit          e_we;
    string       wtg;
    bit          busy;
    for (int b = 0; b < 2; b++) begin
      e_rv[b] = rv[b];
      e_er[b] = rv[b] && !legal(rt[b], rab[b], rr[b], m4);
      e_d[b]  = (rv[b] && !e_er[b]) ? mem[b][pidx(rt[b], rab[b], rr[b], m4)] : 0;
      tg[b]   = tag_of(rt[b], rab[b], rr[b], m4);
    end
    e_we = wv && !legal(wt, wab, wr, m4);
    wtg  = tag_of(wt, wab, wr, m4);
    if (wv && !e_we) mem[wbk][pidx(wt, wab, wr, m4)] = wd;
    busy = wv || rv[0] || rv[1];
    if (!busy) m4 = cfg;
    @(negedge clk);
    for (int b = 0; b < 2; b++) begin
      chk(e_rv[b] ? tg[b] : "R8", $sformatf("rvalid[%0d]", b), orv[b], e_rv[b]);
      if (e_rv[b]) begin
        chk(tg[b], $sformatf("err[%0d]", b), oer[b], e_er[b]);
        chk(tg[b], $sformatf("data[%0d]", b), od[b], e_d[b]);
      end
      chk("R8", $sformatf("ready[%0d]", b), ordy[b], 1);
    end
    chk(wtg, "wr_err", wer, e_we);
    chk("R8", "wr_ready", wrdy, 1);
  endtask

  task automatic idle();
    wv = 0; rv[0] = 0; rv[1] = 0;
  endtask

  task automatic put(int t, bit bk, bit ab, int r, int unsigned d);
    wv = 1; wt = 3'(t); wbk = bk; wab = ab; wr = 7'(r); wd = d;
  endtask

  task automatic get(int b, int t, bit ab, int r);
    rv[b] = 1; rt[b] = 3'(t); rab[b] = ab; rr[b] = 7'(r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cfg = 0; wt = 0; wbk = 0; wab = 0; wr = 0; wd = 0;
    for (int b = 0; b < 2; b++) begin rt[b] = 0; rab[b] = 0; rr[b] = 0; end
    idle();
    for (int b = 0; b < 2; b++) for (int i = 0; i < 128; i++) mem[b][i] = 0;
    m4 = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "rvalid A at reset", orv[0], 0);
    chk("R1", "rvalid B at reset", orv[1], 0);
    chk("R1", "wr_err at reset", wer, 0);
    rst_n = 1;
    @(negedge clk);
    focus = "R1";
    get(0, 0, 1, 127); get(1, 0, 1, 0); tick();
    get(0, 5, 1, 64);  get(1, 3, 1, 99); tick();
    idle(); focus = "";

    // R2: thread 1 writes absolute word 40, thread 6 reads it back
    put(1, 0, 1, 40, 32'hCAFE_0040); tick(); idle();
    get(0, 6, 1, 40); tick(); idle();
    // R3: word 40 is thread 2 local 8 in eight-thread mode
    get(0, 2, 0, 8); tick();
    put(7, 1, 0, 15, 32'h7777_000F); get(0, 7, 0, 15); tick(); idle();
    get(1, 7, 0, 15); tick(); idle();
    get(1, 0, 1, 127); tick(); idle();
    // R5: slice edge in eight-thread mode
    put(3, 0, 0, 16, 32'hBAD0_0010); tick(); idle();
    get(0, 4, 0, 0); get(1, 3, 0, 16); tick(); idle();

    // R6: request four threads while busy, the mode must hold
    focus = "R6";
    cfg = 1;
    get(0, 2, 0, 20); tick();
    put(0, 0, 1, 70, 32'h0000_0070); get(1, 1, 0, 20); tick();
    idle(); tick();
    get(0, 2, 0, 20); get(1, 3, 0, 31); tick(); idle();
    get(0, 1, 0, 8); tick(); idle();
    focus = "";
    // R4: four-thread mapping and limits
    put(3, 1, 0, 31, 32'h4444_001F); tick(); idle();
    get(1, 0, 1, 127); get(0, 1, 0, 8); tick(); idle();
    put(4, 0, 0, 0, 32'hBAD0_0400); get(0, 3, 0, 32); tick(); idle();
    put(2, 0, 0, 32, 32'hBAD0_0220); get(1, 5, 0, 1); tick(); idle();
    get(0, 0, 1, 64); tick(); idle();

    // R7: same-cycle write and read of one word
    focus = "R7";
    put(1, 0, 0, 3, 32'h1234_5678); get(0, 1, 0, 3); tick();
    put(1, 0, 0, 3, 32'h8765_4321); get(0, 0, 1, 35); tick();
    idle(); get(0, 1, 0, 3); tick(); idle();
    // R9: a write to bank A leaves bank B alone
    focus = "R9";
    put(0, 0, 1, 10, 32'hAAAA_000A); get(1, 0, 1, 10); tick();
    put(0, 1, 1, 11, 32'hBBBB_000B); get(0, 0, 1, 11); tick(); idle();
    get(0, 0, 1, 10); get(1, 0, 1, 10); tick();
    get(0, 0, 1, 11); get(1, 0, 1, 11); tick(); idle();
    // R8: no read leaves rvalid low
    focus = "R8";
    tick(); idle();
    focus = "";

    // Random traffic with occasional idle cycles and thread-count changes
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 29) == 0) cfg = ~cfg;
      if ($urandom_range(0, 9) == 0) begin
        idle();
      end else begin
        wv = ($urandom_range(0, 9) < 6);
        wt = 3'($urandom_range(0, 7)); wbk = 1'($urandom_range(0, 1));
        wab = 1'($urandom_range(0, 1));
        wr = wab ? 7'($urandom_range(0, 127)) : 7'($urandom_range(0, 39));
        wd = $urandom;
        for (int b = 0; b < 2; b++) begin
          rv[b] = ($urandom_range(0, 9) < 7);
          rt[b] = 3'($urandom_range(0, 7)); rab[b] = 1'($urandom_range(0, 1));
          rr[b] = rab[b] ? 7'($urandom_range(0, 127)) : 7'($urandom_range(0, 39));
        end
      end
      tick();
    end
    idle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule